// File: doc/BRIEF.md
# Video Input Timing Detector

This block sits on the input side of a video capture path. It watches a clocked pixel stream made of a data-enable qualifier, horizontal and vertical sync pulses (active high), a field flag and a lock level from the receiver. From these it measures the line and frame geometry: samples per line with and without blanking, and lines per field with and without blanking, kept separately for each of the two field parities. It also decides whether the stream is interlaced and whether the line length has settled.

The results go to a word-addressed register port that software reads. That port also carries live and sticky status flags, two write-one-to-clear interrupt sources and the fill level of an external input buffer. The block produces no pixels itself. It reports that capture is running ("producing") while the measured resolution is valid and the lock input is high. A horizontal line runs from one rising edge of horizontal sync to the next. A field runs from one rising edge of vertical sync to the next.

Top module: `vid_timing_monitor`

## Requirements
- R1: Address 1 (status word) bit 0 reads 1 exactly when the resolution-valid flag is set and `vid_lock` is high. Bits 6..1 of that word read 0. Addresses 0 and 10..15 read as all zeros.
- R2: Status bit 7 goes high when the field flag sampled at a vertical sync rising edge differs from the one sampled at the previous edge. It goes low when two successive edges sample the same value.
- R3: Status bit 8 is 1 when at least two of the three most recently completed lines had the same total length in clock cycles.
- R4: Status bit 9 is set one cycle after `buf_overflow` is high. It then stays set until a write to address 1 with bit 9 = 1. Writing 0 there leaves it set.
- R5: Status bit 10 (resolution valid) is set when a field ends with measured counts identical to those of the previous field of the same parity. A mismatch against that previous field clears it.
- R6: Status bit 11 always equals the current level of `vid_lock`.
- R7: Address 2 bit 1 is the status-update interrupt and bit 2 is the end-of-field interrupt. Each stays set until written with a 1 in its own bit position. `irq` is the OR of the two.
- R8: The status-update interrupt is set one cycle after any of the interlaced, stable or resolution-valid flags changes value.
- R9: The end-of-field interrupt is set when a vertical sync rising edge is processed while the block is producing.
- R10: Address 3 returns `buf_level`. Address 4 returns active samples per line and address 7 returns total samples per line. Addresses 5 and 8 return field-0 active and total lines. Addresses 6 and 9 return field-1 active and total lines. All counts are updated only when a field ends.
- R11: While the stream is classed as progressive, a completed field is written to both the field-0 and the field-1 count registers.
- R12: When `vid_lock` is low, the resolution-valid flag is cleared and the stored per-parity history is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_de | input | 1 | Data-enable qualifier, high on active samples |
| vid_hs | input | 1 | Horizontal sync, active high |
| vid_vs | input | 1 | Vertical sync, active high |
| vid_field | input | 1 | Field flag, 0 or 1 |
| vid_lock | input | 1 | Receiver lock level |
| buf_level | input | LVL_W | Fill level of the external input buffer |
| buf_overflow | input | 1 | High for a cycle when the input buffer overflows |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, OR of pending interrupts |

## Verification
The bound checker watches a set of cycle-level rules on every clock. It checks that the status padding bits are zero and that the lock bit follows the input. It checks that the overflow and status-update bits hold until their clearing write. It checks that any change of a detector flag raises the status-update interrupt, that a vertical sync edge while producing raises the end-of-field interrupt, and that the resolution flag is cleared while lock is absent. Only the directed scenarios can show that the measured counts are right. These scenarios cover the progressive mirroring into the field-1 registers, the progressive-to-interlaced switch with separate per-parity line counts, and the two-of-three stability judgement with non-adjacent matching lines.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    localparam int SAMP_W = 12;
    localparam int LINE_W = 11;
    localparam int HIST_N = 3;

    typedef struct packed {
        logic [SAMP_W-1:0] act_samp;
        logic [SAMP_W-1:0] tot_samp;
        logic [LINE_W-1:0] act_lines;
        logic [LINE_W-1:0] tot_lines;
    } geom_t;
endpackage

// File: rtl/vtm_line_meter.sv
module vtm_line_meter
    import vtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_de,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic              vid_field,
    output logic              line_done,
    output logic [SAMP_W-1:0] line_tot,
    output logic [SAMP_W-1:0] line_act,
    output logic              stable,
    output logic              vs_evt,
    output logic              vs_field
);
    typedef struct packed {
        logic                          hs_q;
        logic                          vs_q;
        logic                          seen_hs;
        logic [SAMP_W-1:0]             cnt_tot;
        logic [SAMP_W-1:0]             cnt_act;
        logic                          done;
        logic [SAMP_W-1:0]             tot;
        logic [SAMP_W-1:0]             act;
        logic [HIST_N-1:0][SAMP_W-1:0] hist;
        logic [HIST_N-1:0]             hval;
        logic                          stable;
        logic                          vs_evt;
        logic                          vs_field;
    } lm_state_t;

    lm_state_t s_q, s_d;
    logic      hs_rise;
    logic [HIST_N*HIST_N-1:0] pair_eq;

    // pairwise match matrix over the line-length history (upper triangle only)
    for (genvar i = 0; i < HIST_N; i++) begin : g_row
        for (genvar j = 0; j < HIST_N; j++) begin : g_col
            if (j > i) begin : g_pair
                assign pair_eq[i*HIST_N+j] = s_d.hval[i] && s_d.hval[j] &&
                                             (s_d.hist[i] == s_d.hist[j]);
            end else begin : g_none
                assign pair_eq[i*HIST_N+j] = 1'b0;
            end
        end
    end

    assign hs_rise = vid_hs && !s_q.hs_q;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.vs_evt = 1'b0;
        s_d.hs_q   = vid_hs;
        s_d.vs_q   = vid_vs;
        if (hs_rise) begin
            if (s_q.seen_hs) begin
                s_d.done = 1'b1;
                s_d.tot  = s_q.cnt_tot;
                s_d.act  = s_q.cnt_act;
                for (int k = HIST_N-1; k > 0; k--) begin
                    s_d.hist[k] = s_q.hist[k-1];
                    s_d.hval[k] = s_q.hval[k-1];
                end
                s_d.hist[0] = s_q.cnt_tot;
                s_d.hval[0] = 1'b1;
            end
            s_d.seen_hs = 1'b1;
            s_d.cnt_tot = SAMP_W'(1);
            s_d.cnt_act = SAMP_W'(vid_de);
        end else begin
            if (s_q.cnt_tot != '1) s_d.cnt_tot = s_q.cnt_tot + 1'b1;
            if (vid_de && s_q.cnt_act != '1) s_d.cnt_act = s_q.cnt_act + 1'b1;
        end
        if (vid_vs && !s_q.vs_q) begin
            s_d.vs_evt   = 1'b1;
            s_d.vs_field = vid_field;
        end
    end

    // stable flag registered from the pairwise matches of the next history
    logic stable_d;
    assign stable_d = |pair_eq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q        <= s_d;
            s_q.stable <= stable_d;
        end
    end

    assign line_done = s_q.done;
    assign line_tot  = s_q.tot;
    assign line_act  = s_q.act;
    assign stable    = s_q.stable;
    assign vs_evt    = s_q.vs_evt;
    assign vs_field  = s_q.vs_field;
endmodule

// File: rtl/vtm_field_meter.sv
module vtm_field_meter
    import vtm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_done,
    input  logic [SAMP_W-1:0] line_tot,
    input  logic [SAMP_W-1:0] line_act,
    input  logic              vs_evt,
    input  logic              vs_field,
    input  logic              vid_lock,
    output logic              res_valid,
    output logic              interlaced,
    output geom_t             geom_f0,
    output geom_t             geom_f1
);
    typedef struct packed {
        logic              seen_vs;
        logic              prev_field;
        logic [LINE_W-1:0] lcnt_tot;
        logic [LINE_W-1:0] lcnt_act;
        logic [SAMP_W-1:0] last_act;
        logic [SAMP_W-1:0] last_tot;
        logic              interlaced;
        logic              res_valid;
        logic [1:0]        hval;
        geom_t [1:0]       hist;
        geom_t [1:0]       shown;
    } fm_state_t;

    fm_state_t s_q, s_d;
    geom_t     cur;
    logic      add_tot, add_act, par, ilace_new;
    logic [SAMP_W-1:0] act_now, tot_now;

    always_comb begin
        add_tot = line_done;
        add_act = line_done && (line_act != '0);
        act_now = add_act   ? line_act : s_q.last_act;
        tot_now = line_done ? line_tot : s_q.last_tot;

        cur.act_samp  = act_now;
        cur.tot_samp  = tot_now;
        cur.act_lines = s_q.lcnt_act + LINE_W'(add_act);
        cur.tot_lines = s_q.lcnt_tot + LINE_W'(add_tot);

        par       = s_q.prev_field;
        ilace_new = vs_field != s_q.prev_field;

        s_d          = s_q;
        s_d.last_act = act_now;
        s_d.last_tot = tot_now;

        if (vs_evt) begin
            if (s_q.seen_vs) begin
                s_d.interlaced = ilace_new;
                if (ilace_new) begin
                    s_d.shown[par] = cur;
                end else begin
                    s_d.shown[0] = cur;
                    s_d.shown[1] = cur;
                end
                if (s_q.hval[par]) begin
                    s_d.res_valid = (s_q.hist[par] == cur);
                end
                s_d.hist[par] = cur;
                s_d.hval[par] = 1'b1;
            end
            s_d.seen_vs    = 1'b1;
            s_d.prev_field = vs_field;
            s_d.lcnt_tot   = '0;
            s_d.lcnt_act   = '0;
        end else begin
            if (add_tot && s_q.lcnt_tot != '1) s_d.lcnt_tot = s_q.lcnt_tot + 1'b1;
            if (add_act && s_q.lcnt_act != '1) s_d.lcnt_act = s_q.lcnt_act + 1'b1;
        end

        if (!vid_lock) begin
            s_d.res_valid = 1'b0;
            s_d.hval      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_valid  = s_q.res_valid;
    assign interlaced = s_q.interlaced;
    assign geom_f0    = s_q.shown[0];
    assign geom_f1    = s_q.shown[1];
endmodule

// File: rtl/vtm_regs.sv
module vtm_regs
    import vtm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              producing,
    input  logic              interlaced,
    input  logic              stable,
    input  logic              res_valid,
    input  logic              vid_lock,
    input  logic              vs_evt,
    input  logic              buf_overflow,
    input  logic [LVL_W-1:0]  buf_level,
    input  geom_t             geom_f0,
    input  geom_t             geom_f1,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ovf,
    output logic              int_upd,
    output logic              int_eof,
    output logic              irq
);
    localparam int BIT_OVF = 9;
    localparam int BIT_UPD = 1;
    localparam int BIT_EOF = 2;

    typedef struct packed {
        logic       ovf;
        logic       int_upd;
        logic       int_eof;
        logic [2:0] prev_flags;
    } rg_state_t;

    rg_state_t s_q, s_d;
    logic      wr_status, wr_int;
    logic [2:0] flags;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[DATA_W-1:BIT_OVF+1], reg_wdata[BIT_OVF-1:BIT_EOF+1],
                            reg_wdata[0]};

    assign wr_status = reg_wr && (reg_addr == ADDR_W'(1));
    assign wr_int    = reg_wr && (reg_addr == ADDR_W'(2));
    assign flags     = {res_valid, interlaced, stable};

    always_comb begin
        s_d            = s_q;
        s_d.prev_flags = flags;
        if (wr_status && reg_wdata[BIT_OVF]) s_d.ovf     = 1'b0;
        if (wr_int && reg_wdata[BIT_UPD])    s_d.int_upd = 1'b0;
        if (wr_int && reg_wdata[BIT_EOF])    s_d.int_eof = 1'b0;
        // new events take precedence over a clear in the same cycle
        if (buf_overflow)                    s_d.ovf     = 1'b1;
        if (flags != s_q.prev_flags)         s_d.int_upd = 1'b1;
        if (vs_evt && producing)             s_d.int_eof = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(1): reg_rdata = DATA_W'({vid_lock, res_valid, s_q.ovf, stable,
                                             interlaced, 6'b0, producing});
            ADDR_W'(2): reg_rdata = DATA_W'({s_q.int_eof, s_q.int_upd, 1'b0});
            ADDR_W'(3): reg_rdata = DATA_W'(buf_level);
            ADDR_W'(4): reg_rdata = DATA_W'(geom_f0.act_samp);
            ADDR_W'(5): reg_rdata = DATA_W'(geom_f0.act_lines);
            ADDR_W'(6): reg_rdata = DATA_W'(geom_f1.act_lines);
            ADDR_W'(7): reg_rdata = DATA_W'(geom_f0.tot_samp);
            ADDR_W'(8): reg_rdata = DATA_W'(geom_f0.tot_lines);
            ADDR_W'(9): reg_rdata = DATA_W'(geom_f1.tot_lines);
            default:    reg_rdata = '0;
        endcase
    end

    logic unused_f1_samp;
    assign unused_f1_samp = ^{geom_f1.act_samp, geom_f1.tot_samp};

    assign ovf     = s_q.ovf;
    assign int_upd = s_q.int_upd;
    assign int_eof = s_q.int_eof;
    assign irq     = s_q.int_upd || s_q.int_eof;
endmodule

// File: rtl/vid_timing_monitor.sv
module vid_timing_monitor
    import vtm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_de,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic              vid_field,
    input  logic              vid_lock,
    input  logic [LVL_W-1:0]  buf_level,
    input  logic              buf_overflow,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic              line_done, stable, vs_evt, vs_field;
    logic [SAMP_W-1:0] line_tot, line_act;
    logic              res_valid, interlaced, producing;
    logic              ovf, int_upd, int_eof;
    geom_t             geom_f0, geom_f1;

    assign producing = res_valid && vid_lock;

    vtm_line_meter u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid_de    (vid_de),
        .vid_hs    (vid_hs),
        .vid_vs    (vid_vs),
        .vid_field (vid_field),
        .line_done (line_done),
        .line_tot  (line_tot),
        .line_act  (line_act),
        .stable    (stable),
        .vs_evt    (vs_evt),
        .vs_field  (vs_field)
    );

    vtm_field_meter u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_done  (line_done),
        .line_tot   (line_tot),
        .line_act   (line_act),
        .vs_evt     (vs_evt),
        .vs_field   (vs_field),
        .vid_lock   (vid_lock),
        .res_valid  (res_valid),
        .interlaced (interlaced),
        .geom_f0    (geom_f0),
        .geom_f1    (geom_f1)
    );

    vtm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .producing    (producing),
        .interlaced   (interlaced),
        .stable       (stable),
        .res_valid    (res_valid),
        .vid_lock     (vid_lock),
        .vs_evt       (vs_evt),
        .buf_overflow (buf_overflow),
        .buf_level    (buf_level),
        .geom_f0      (geom_f0),
        .geom_f1      (geom_f1),
        .reg_rdata    (reg_rdata),
        .ovf          (ovf),
        .int_upd      (int_upd),
        .int_eof      (int_eof),
        .irq          (irq)
    );
endmodule

// File: rtl/vtm_checker.sv
module vtm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       st_sel,
    input logic [5:0] st_pad,
    input logic       st_lock_bit,
    input logic       vid_lock,
    input logic       buf_overflow,
    input logic       clr_ovf,
    input logic       clr_upd,
    input logic       ovf,
    input logic       int_upd,
    input logic       int_eof,
    input logic       res_valid,
    input logic       interlaced,
    input logic       stable,
    input logic       producing,
    input logic       vs_evt
);
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_sel |-> (st_pad == 6'd0));

    p_prod_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        producing |-> (vid_lock && res_valid));

    p_lock_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_sel |-> (st_lock_bit == vid_lock));

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_overflow |=> ovf);

    p_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    p_upd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_upd && !clr_upd) |=> int_upd);

    p_upd_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_valid, interlaced, stable}) |=> int_upd);

    p_eof_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_evt && producing) |=> int_eof);

    p_lock_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_lock |=> !res_valid);
endmodule

bind vid_timing_monitor vtm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_sel       (reg_addr == ADDR_W'(1)),
    .st_pad       (reg_rdata[6:1]),
    .st_lock_bit  (reg_rdata[11]),
    .vid_lock     (vid_lock),
    .buf_overflow (buf_overflow),
    .clr_ovf      (reg_wr && (reg_addr == ADDR_W'(1)) && reg_wdata[9]),
    .clr_upd      (reg_wr && (reg_addr == ADDR_W'(2)) && reg_wdata[1]),
    .ovf          (ovf),
    .int_upd      (int_upd),
    .int_eof      (int_eof),
    .res_valid    (res_valid),
    .interlaced   (interlaced),
    .stable       (stable),
    .producing    (producing),
    .vs_evt       (vs_evt)
);

// File: tb/tb_vid_timing_monitor.sv
module tb_vid_timing_monitor;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int LVL_W  = 10;
    localparam int HTOT   = 20;
    localparam int DE_AT  = 4;
    localparam int DE_LEN = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
    logic              vid_field = 1'b0, vid_lock = 1'b1;
    logic [LVL_W-1:0]  buf_level = '0;
    logic              buf_overflow = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vid_timing_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs),
        .vid_field(vid_field), .vid_lock(vid_lock), .buf_level(buf_level),
        .buf_overflow(buf_overflow), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic drive_line(input int len, input bit vs, input bit act);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            vid_hs = (c < 2);
            vid_vs = vs;
            vid_de = act && (c >= DE_AT) && (c < DE_AT + DE_LEN);
        end
    endtask

    task automatic drive_field(input bit par, input int nlines, input int nact);
        vid_field = par;
        for (int l = 0; l < nlines; l++)
            drive_line(HTOT, l < 2, (l >= 2) && (l < 2 + nact));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(1, d); check("R6 status after reset shows lock only", d, 32'h800);
        rd(2, d); check("R7 no interrupt after reset", d, 32'h0);
        rd(4, d); check("R10 sample count zero after reset", d, 32'h0);
        check("R7 irq low after reset", {31'b0, irq}, 32'h0);
        rd(0, d);  check("R1 address 0 reads zero", d, 32'h0);
        rd(12, d); check("R1 address 12 reads zero", d, 32'h0);
    endtask

    task automatic t_progressive;
        logic [31:0] d;
        for (int f = 0; f < 4; f++) drive_field(1'b0, 10, 6);
        rd(1, d); check("R1 R5 R3 progressive status", d, 32'hD01);
        rd(4, d); check("R10 active samples", d, 12);
        rd(7, d); check("R10 total samples", d, 20);
        rd(5, d); check("R10 f0 active lines", d, 6);
        rd(8, d); check("R10 f0 total lines", d, 10);
        rd(6, d); check("R11 f1 active lines mirror", d, 6);
        rd(9, d); check("R11 f1 total lines mirror", d, 10);
        rd(2, d); check("R8 R9 both interrupts pending", d, 32'h6);
    endtask

    task automatic t_int_clear;
        logic [31:0] d;
        wr(2, 32'h2);
        rd(2, d); check("R7 clear status-update only", d, 32'h4);
        check("R7 irq still high", {31'b0, irq}, 32'h1);
        wr(2, 32'h4);
        rd(2, d); check("R7 clear end-of-field", d, 32'h0);
        check("R7 irq low after clears", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_interlaced;
        logic [31:0] d;
        drive_field(1'b1, 11, 7);
        drive_field(1'b0, 10, 6);
        drive_field(1'b1, 11, 7);
        drive_field(1'b0, 10, 6);
        drive_field(1'b1, 11, 7);
        rd(1, d); check("R2 interlaced status", d, 32'hD81);
        rd(5, d); check("R10 f0 active lines interlaced", d, 6);
        rd(6, d); check("R10 f1 active lines interlaced", d, 7);
        rd(8, d); check("R10 f0 total lines interlaced", d, 10);
        rd(9, d); check("R10 f1 total lines interlaced", d, 11);
        rd(2, d); check("R9 R8 interrupts after interlace", d, 32'h6);
        wr(2, 32'h6);
    endtask

    task automatic t_stability;
        logic [31:0] d;
        drive_line(23, 1'b0, 1'b1);
        drive_line(26, 1'b0, 1'b1);
        drive_line(29, 1'b0, 1'b1);
        drive_line(40, 1'b0, 1'b1);
        rd(1, d); check("R3 three distinct lengths unstable", d & 32'h100, 32'h0);
        rd(2, d); check("R8 stable drop raises update", d, 32'h2);
        drive_line(29, 1'b0, 1'b1);
        drive_line(50, 1'b0, 1'b1);
        rd(1, d); check("R3 non-adjacent pair stable", d & 32'h100, 32'h100);
        wr(2, 32'h6);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        buf_level = 10'h2A5;
        rd(3, d); check("R10 buffer level", d, 32'h2A5);
        @(negedge clk); buf_overflow = 1'b1;
        @(negedge clk); buf_overflow = 1'b0;
        rd(1, d); check("R4 overflow set", d & 32'h200, 32'h200);
        wr(1, 32'h0);
        rd(1, d); check("R4 write 0 keeps overflow", d & 32'h200, 32'h200);
        wr(1, 32'h200);
        rd(1, d); check("R4 write 1 clears overflow", d & 32'h200, 32'h0);
    endtask

    task automatic t_lock_drop;
        logic [31:0] d;
        @(negedge clk); vid_lock = 1'b0;
        repeat (3) @(negedge clk);
        rd(1, d); check("R12 R6 R1 lock drop status", d, 32'h180);
        rd(2, d); check("R8 update on resolution loss", d, 32'h2);
        check("R7 irq high after loss", {31'b0, irq}, 32'h1);
        @(negedge clk); vid_lock = 1'b1;
        rd(1, d); check("R12 valid stays clear after relock", d, 32'h980);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_progressive();
        t_int_clear();
        t_interlaced();
        t_stability();
        t_overflow();
        t_lock_drop();
        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule